// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the reset line of a processor from two digital sources. The first is a supply-good flag. It comes from an external comparator and is already synchronized to the block's clock. The second is a one-cycle timeout strobe from a watchdog. While the supply flag is low, reset stays asserted. After the supply recovers, or after a watchdog strobe, reset stays asserted for a fixed interval and then releases. Any new supply dip or watchdog strobe during that interval starts the whole interval again.

Time is counted in cycles of a slow reference clock, and the interval length is a parameter. With the default of 200 ticks and a 1 kHz reference, the pulse is about 200 ms. The block drives an active-low reset, an active-high reset and an asserted-status flag. The status flag lets the watchdog hold itself cleared while reset is active. A build option chooses between an up-counting and a down-counting interval timer. Both give the same behaviour at the ports.

Top module: `svr_reset_pulse`

## Requirements
- R1: Whenever `supply_ok` is sampled low at a rising clock edge, `rst_out` is high and `rst_n_out` is low after that edge.
- R2: Reset releases at the PULSE_TICKS-th rising edge after the last edge that saw `supply_ok` low, `wd_trip` high or `rst` high. Until that edge it stays asserted.
- R3: A supply dip that happens while a pulse is being timed discards the elapsed count. After the supply recovers, a full pulse of PULSE_TICKS is timed again.
- R4: A one-cycle `wd_trip` strobe while reset is released asserts reset after that edge, for a pulse of PULSE_TICKS cycles.
- R5: A `wd_trip` strobe while a pulse is being timed restarts the full pulse width.
- R6: A `wd_trip` strobe while `supply_ok` is low does not change the pulse that follows supply recovery. That pulse is still PULSE_TICKS cycles long.
- R7: `rst_out` is always the logical inverse of `rst_n_out`.
- R8: `rst_active` is high exactly when `rst_out` is high.
- R9: A synchronous `rst` asserts reset with the timer cleared. A full pulse follows the release of `rst`.
- R10: The down-counting timer variant (COUNT_DOWN=1) gives the same port behaviour as the up-counting one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow reference clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high system reset |
| supply_ok | input | 1 | Synchronized supply-above-threshold flag |
| wd_trip | input | 1 | One-cycle watchdog timeout strobe |
| rst_n_out | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| rst_active | output | 1 | High while reset is asserted |

## Verification
The bench measures the exact pulse length for four starting causes: supply recovery, a watchdog strobe, system reset, and a restart partway through a pulse. An off-by-one in the terminal count would make every measured pulse one cycle short or long. A design that kept the elapsed count across a dip, or ignored a mid-pulse strobe, would release early in the restart cases. A design that armed a pulse from a strobe seen while the supply was low would show a wrong length once the supply recovers. Both timer variants run the same long random sequence side by side against a cycle-level reference model.

// File: rtl/svr_pkg.sv
package svr_pkg;

   // Command from the trigger logic to the interval timer
   typedef enum logic [1:0] {
      TMR_IDLE    = 2'd0,
      TMR_RESTART = 2'd1,
      TMR_COUNT   = 2'd2
   } tmr_cmd_e;

endpackage

// File: rtl/svr_trigger.sv
module svr_trigger (
   input  logic              supply_ok,
   input  logic              wd_trip,
   input  logic              asserted,
   output svr_pkg::tmr_cmd_e cmd
);
   import svr_pkg::*;

   always_comb begin
      if (!supply_ok || wd_trip)
         cmd = TMR_RESTART;
      else if (asserted)
         cmd = TMR_COUNT;
      else
         cmd = TMR_IDLE;
   end

endmodule

// File: rtl/svr_interval_timer.sv
module svr_interval_timer #(
   parameter int unsigned TICKS      = 200,
   parameter bit          COUNT_DOWN = 1'b0,
   localparam int unsigned W         = (TICKS > 2) ? $clog2(TICKS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  svr_pkg::tmr_cmd_e cmd,
   output logic              done
);
   import svr_pkg::*;

   localparam logic [W-1:0] LAST = W'(TICKS - 1);
   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] cnt_q;

   generate
      if (COUNT_DOWN) begin : g_down
         assign done = (cmd == TMR_COUNT) && (cnt_q == ZERO);

         always_ff @(posedge clk) begin
            if (rst || cmd != TMR_COUNT || done)
               cnt_q <= LAST;
            else
               cnt_q <= cnt_q - 1'b1;
         end

         // R2
         dn_step_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd == TMR_COUNT && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));
      end else begin : g_up
         assign done = (cmd == TMR_COUNT) && (cnt_q == LAST);

         always_ff @(posedge clk) begin
            if (rst || cmd != TMR_COUNT || done)
               cnt_q <= ZERO;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         // R2
         up_step_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd == TMR_COUNT && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));
      end
   endgenerate

   // R3
   restart_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == TMR_RESTART) |=> (cnt_q == (COUNT_DOWN ? LAST : ZERO)));

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);

endmodule

// File: rtl/svr_out_stage.sv
module svr_out_stage (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic rst_n_q,
   output logic rst_q
);

   always_ff @(posedge clk) begin
      if (rst || set) begin
         rst_q   <= 1'b1;
         rst_n_q <= 1'b0;
      end else if (clr) begin
         rst_q   <= 1'b0;
         rst_n_q <= 1'b1;
      end
   end

   // R7
   polarity_chk: assert property (@(posedge clk) disable iff (rst)
      rst_q != rst_n_q);

endmodule

// File: rtl/svr_reset_pulse.sv
module svr_reset_pulse #(
   parameter int unsigned PULSE_TICKS = 200,
   parameter bit          COUNT_DOWN  = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic supply_ok,
   input  logic wd_trip,
   output logic rst_n_out,
   output logic rst_out,
   output logic rst_active
);
   import svr_pkg::*;

   generate
      if (PULSE_TICKS < 2) begin : g_bad_ticks
         $error("PULSE_TICKS must be at least 2");
      end
   endgenerate

   tmr_cmd_e cmd;
   logic     done;
   logic     rst_q;
   logic     rst_n_q;

   svr_trigger u_trig (
      .supply_ok (supply_ok),
      .wd_trip   (wd_trip),
      .asserted  (rst_q),
      .cmd       (cmd)
   );

   svr_interval_timer #(
      .TICKS      (PULSE_TICKS),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .cmd  (cmd),
      .done (done)
   );

   svr_out_stage u_out (
      .clk     (clk),
      .rst     (rst),
      .set     (cmd == TMR_RESTART),
      .clr     (done),
      .rst_n_q (rst_n_q),
      .rst_q   (rst_q)
   );

   assign rst_n_out  = rst_n_q;
   assign rst_out    = rst_q;
   assign rst_active = rst_q;

   // R1
   supply_lo_chk: assert property (@(posedge clk) disable iff (rst)
      !supply_ok |=> (rst_out && !rst_n_out));

   // R4
   wd_trip_chk: assert property (@(posedge clk) disable iff (rst)
      wd_trip |=> rst_out);

   // R2
   release_src_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst_out) |-> ($past(supply_ok) && !$past(wd_trip)));

   // R9
   sysrst_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> rst_out);

endmodule

// File: tb/svr_reset_pulse_tb.sv
`timescale 1ns/1ps
module svr_reset_pulse_tb;

   localparam int P = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic supply_ok = 1'b0;
   logic wd_trip = 1'b0;
   logic rst_n_out, rst_out, rst_active;
   logic dn_rst_n, dn_rst, dn_act;

   int checks = 0;
   int fails = 0;
   bit done_flag = 1'b0;
   int run = 0;

   always #10 clk = ~clk;

   svr_reset_pulse #(.PULSE_TICKS(P), .COUNT_DOWN(1'b0)) u_dut (
      .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_trip(wd_trip),
      .rst_n_out(rst_n_out), .rst_out(rst_out), .rst_active(rst_active));

   svr_reset_pulse #(.PULSE_TICKS(P), .COUNT_DOWN(1'b1)) u_dut_dn (
      .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_trip(wd_trip),
      .rst_n_out(dn_rst_n), .rst_out(dn_rst), .rst_active(dn_act));

   // Reference model: cycles since last restart cause, saturating at P
   always @(posedge clk) begin
      if (rst || !supply_ok || wd_trip) run <= 0;
      else if (run < P) run <= run + 1;
   end

   function automatic logic exp_asserted(int r);
      return r < P;
   endfunction

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // Cycle monitor against the model
   always @(negedge clk) begin
      if (!rst && !done_flag) begin
         chk("R2", rst_out, exp_asserted(run));
         chk("R7", rst_n_out, !rst_out);
         chk("R8", rst_active, rst_out);
         chk("R10", dn_rst, rst_out);
         chk("R10", dn_rst_n, rst_n_out);
      end
   end

   // Counts asserted cycles starting at the current negedge
   task automatic measure(output int len);
      len = 0;
      while (rst_out && len < 4*P) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic settle();
      supply_ok = 1'b1; wd_trip = 1'b0;
      repeat (P + 3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20ns * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int len;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", rst_out, 1);
      chk("R9", rst_n_out, 0);
      chk("R8", rst_active, 1);
      // R1/R2: release rst with supply low, then recover supply
      rst = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1", rst_out, 1);
      chk("R1", rst_n_out, 0);
      supply_ok = 1'b1;
      measure(len);
      chk("R2", len, P);
      chk("R2", rst_out, 0);

      // R4: watchdog strobe while released
      repeat (3) @(negedge clk);
      wd_trip = 1'b1; @(negedge clk); wd_trip = 1'b0;
      measure(len);
      chk("R4", len, P);

      // R3: dip mid-pulse restarts full width
      settle();
      supply_ok = 1'b0; @(negedge clk); supply_ok = 1'b1;
      repeat (P/2) @(negedge clk);
      supply_ok = 1'b0; @(negedge clk); supply_ok = 1'b1;
      measure(len);
      chk("R3", len, P);

      // R5: strobe mid-pulse restarts
      settle();
      wd_trip = 1'b1; @(negedge clk); wd_trip = 1'b0;
      repeat (P - 3) @(negedge clk);
      wd_trip = 1'b1; @(negedge clk); wd_trip = 1'b0;
      measure(len);
      chk("R5", len, P);

      // R6: strobe while supply low has no extra effect
      settle();
      supply_ok = 1'b0; @(negedge clk);
      wd_trip = 1'b1; @(negedge clk); wd_trip = 1'b0;
      @(negedge clk);
      supply_ok = 1'b1;
      measure(len);
      chk("R6", len, P);

      // R9: system reset while released
      settle();
      chk("R9", rst_out, 0);
      rst = 1'b1; @(negedge clk);
      chk("R9", rst_out, 1);
      rst = 1'b0; @(negedge clk);
      measure(len);
      chk("R9", len, P - 1);

      // Random phase
      settle();
      for (int i = 0; i < 30000; i++) begin
         supply_ok = ($urandom_range(0, 199) != 0);
         wd_trip   = ($urandom_range(0, 149) == 0);
         @(negedge clk);
      end
      supply_ok = 1'b1; wd_trip = 1'b0;
      repeat (P + 2) @(negedge clk);
      chk("R2", rst_out, 0);
      finish_run();
   end

endmodule